// File: doc/BRIEF.md
# Framed Message Byte Sender

This block sends a single message held in memory as a stream of bytes, one byte per clock, and marks the stream with two side-band pins. One pin pulses once to open the message and the other pulses once to close it. Software loads a byte pointer and a byte count into two registers. It then writes the control register with the run bit and the master bit both set. The engine reads 32-bit words through a simple request/valid port. It unpacks each word into bytes, taking them from consecutive byte addresses in little-endian lane order, and emits exactly the requested number of bytes.

When the last byte has gone out, the engine pulses the closing pin and clears its run bit. It then sets a completion flag, and the flag raises a level interrupt if the interrupt enable is on. After that the engine sends nothing until software starts it again. The framing pins are only driven when the master bit is set. A run request made without the master bit is refused.

Top module: `msg_frame_tx`

## Requirements
- R1: After reset all outputs are low and every register reads as zero.
- R2: Writing the control register (address 0) with bit 0 (run) and bit 1 (master) set starts a message using the byte pointer at address 1 and the byte count at address 2. `frame_start` is high for exactly one cycle, and the first data byte is on `out_byte` with `out_valid` high in the very next cycle.
- R3: The bytes come from consecutive byte addresses, starting at the pointer. The byte at address a is bits [8*(a mod 4)+7 : 8*(a mod 4)] of the memory word at word address a/4. At most one byte is sent per cycle, with `out_valid`, and exactly count bytes are sent.
- R4: After the last byte, `frame_end` is high for exactly one cycle, and the run bit (control bit 0) reads 0 from then on.
- R5: The done flag (status register at address 3, bit 0) is set in the cycle after `frame_end`. `irq` equals done AND interrupt enable (control bit 2). The status register's bit 1 reads busy while a message is in progress.
- R6: Writing control bit 3 (acknowledge) clears the done flag. If the acknowledge lands on the same clock edge that sets the done flag, the flag stays set.
- R7: A byte count of zero gives `frame_start`, then `frame_end` in the next cycle, with no data bytes in between.
- R8: A control write with run set but master clear starts nothing: no pulses, no bytes, busy stays 0 and the run bit reads 0.
- R9: Between messages the outputs stay quiet, and no memory request is made, until run is written again. A later run sends a fresh message.
- R10: `mem_req` stays high with `mem_addr` unchanged until `mem_valid`. Successive word addresses rise by one, starting at pointer/4.
- R11: `frame_start`, `frame_end` and `out_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one byte per cycle |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 pointer, 2 count, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Word read request, held until `mem_valid` |
| mem_addr | output | ADDR_W-2 | Word address of the request |
| mem_valid | input | 1 | Read data returned, completes the request |
| mem_rdata | input | 32 | Read data word |
| out_valid | output | 1 | `out_byte` carries a message byte |
| out_byte | output | 8 | Message byte |
| frame_start | output | 1 | One-cycle opening pulse (master only) |
| frame_end | output | 1 | One-cycle closing pulse (master only) |
| irq | output | 1 | Level interrupt: done and enabled |

## Verification
Completion and acknowledge can fall on the same clock edge. The hardware wants to set the done flag as it leaves the closing state, while software clears the flag with the acknowledge bit. The bench provokes this by watching for `frame_end` and driving the acknowledge write in that same cycle, so both land on one edge. The design is correct only if the status register still shows done afterwards, and a later acknowledge on its own clears the flag.

// File: rtl/msg_frame_pkg.sv
package msg_frame_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PREP,
        SQ_OPEN,
        SQ_BODY,
        SQ_CLOSE
    } sq_state_e;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_PTR  = 2'd1;
    localparam logic [1:0] RA_LEN  = 2'd2;
    localparam logic [1:0] RA_STAT = 2'd3;

    localparam int CB_RUN    = 0;
    localparam int CB_MASTER = 1;
    localparam int CB_IRQEN  = 2;
    localparam int CB_ACK    = 3;

    typedef struct packed {
        logic irq_en;
        logic master;
        logic run;
    } ctl_bits_t;

    typedef struct packed {
        logic busy;
        logic done;
    } stat_bits_t;

    function automatic ctl_bits_t decode_ctl(input logic [31:0] w);
        ctl_bits_t c;
        c.irq_en = w[CB_IRQEN];
        c.master = w[CB_MASTER];
        c.run    = w[CB_RUN];
        return c;
    endfunction

    function automatic logic is_ack(input logic [31:0] w);
        return w[CB_ACK];
    endfunction

endpackage

// File: rtl/msg_frame_regs.sv
module msg_frame_regs
    import msg_frame_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              finish,
    output logic              launch,
    output logic [ADDR_W-1:0] ptr,
    output logic [LEN_W-1:0]  len,
    output logic              master,
    output logic              done,
    output logic              irq
);
    ctl_bits_t  ctl_q;
    ctl_bits_t  wr_ctl_bits;
    stat_bits_t stat;
    logic       wr_ctl;
    logic       unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign wr_ctl       = reg_wr && (reg_addr == RA_CTRL);
    assign wr_ctl_bits  = decode_ctl(reg_wdata);
    assign launch       = wr_ctl && wr_ctl_bits.run && wr_ctl_bits.master
                          && !busy && !ctl_q.run;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            ptr   <= '0;
            len   <= '0;
            done  <= 1'b0;
        end else begin
            if (wr_ctl) begin
                ctl_q.master <= wr_ctl_bits.master;
                ctl_q.irq_en <= wr_ctl_bits.irq_en;
            end
            if (launch) begin
                ctl_q.run <= 1'b1;
            end else if (finish) begin
                ctl_q.run <= 1'b0;
            end
            if (reg_wr && (reg_addr == RA_PTR)) begin
                ptr <= reg_wdata[ADDR_W-1:0];
            end
            if (reg_wr && (reg_addr == RA_LEN)) begin
                len <= reg_wdata[LEN_W-1:0];
            end
            // completion wins over a simultaneous acknowledge
            if (finish) begin
                done <= 1'b1;
            end else if (wr_ctl && is_ack(reg_wdata)) begin
                done <= 1'b0;
            end
        end
    end

    assign stat.busy = busy;
    assign stat.done = done;
    assign master    = ctl_q.master;
    assign irq       = done && ctl_q.irq_en;

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = 32'(ctl_q);
            RA_PTR:  reg_rdata = 32'(ptr);
            RA_LEN:  reg_rdata = 32'(len);
            default: reg_rdata = 32'(stat);
        endcase
    end

endmodule

// File: rtl/msg_frame_fetch.sv
module msg_frame_fetch #(
    parameter int WORD_BYTES = 4,
    parameter int WADDR_W    = 14,
    parameter int CNT_W      = 13,
    parameter int DEPTH      = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    launch,
    input  logic [WADDR_W-1:0]      base,
    input  logic [CNT_W-1:0]        words,
    output logic                    mem_req,
    output logic [WADDR_W-1:0]      mem_addr,
    input  logic                    mem_valid,
    input  logic [WORD_BYTES*8-1:0] mem_rdata,
    input  logic                    pop,
    output logic [WORD_BYTES*8-1:0] head,
    output logic                    head_valid
);
    localparam int DATA_W = WORD_BYTES * 8;
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W  = $clog2(DEPTH + 1);

    logic [DATA_W-1:0]  slots [DEPTH];
    logic [PTR_W-1:0]   rd_p, wr_p;
    logic [OCC_W-1:0]   occ;
    logic [WADDR_W-1:0] wptr;
    logic [CNT_W-1:0]   left;
    logic               push;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign mem_req    = (left != '0) && (occ < OCC_W'(DEPTH));
    assign mem_addr   = wptr;
    assign push       = mem_req && mem_valid;
    assign head       = slots[rd_p];
    assign head_valid = (occ != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_p <= '0;
            wr_p <= '0;
            occ  <= '0;
            wptr <= '0;
            left <= '0;
        end else if (launch) begin
            rd_p <= '0;
            wr_p <= '0;
            occ  <= '0;
            wptr <= base;
            left <= words;
        end else begin
            if (push) begin
                wr_p <= step(wr_p);
                wptr <= wptr + 1'b1;
                left <= left - 1'b1;
            end
            if (pop) begin
                rd_p <= step(rd_p);
            end
            occ <= occ + OCC_W'(push) - OCC_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_p] <= mem_rdata;
        end
    end

endmodule

// File: rtl/msg_frame_seq.sv
module msg_frame_seq
    import msg_frame_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter int LEN_W      = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          launch,
    input  logic [$clog2(WORD_BYTES)-1:0] start_lane,
    input  logic [LEN_W-1:0]              len,
    input  logic [WORD_BYTES*8-1:0]       head,
    input  logic                          head_valid,
    output logic                          pop,
    output logic                          out_valid,
    output logic [7:0]                    out_byte,
    output logic                          open_pulse,
    output logic                          close_pulse,
    output logic                          busy
);
    localparam int LANE_W = $clog2(WORD_BYTES);

    sq_state_e         state;
    logic [LANE_W-1:0] lane;
    logic [LEN_W-1:0]  left;
    logic [7:0]        lanes [WORD_BYTES];
    logic              last_byte;

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign lanes[g] = head[g*8 +: 8];
    end

    assign last_byte   = (left == LEN_W'(1));
    assign out_valid   = (state == SQ_BODY) && head_valid;
    assign out_byte    = lanes[lane];
    assign pop         = out_valid && ((lane == LANE_W'(WORD_BYTES - 1)) || last_byte);
    assign open_pulse  = (state == SQ_OPEN);
    assign close_pulse = (state == SQ_CLOSE);
    assign busy        = (state != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            lane  <= '0;
            left  <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (launch) begin
                        state <= SQ_PREP;
                        lane  <= start_lane;
                        left  <= len;
                    end
                end
                SQ_PREP: begin
                    if ((left == '0) || head_valid) begin
                        state <= SQ_OPEN;
                    end
                end
                SQ_OPEN: begin
                    state <= (left == '0) ? SQ_CLOSE : SQ_BODY;
                end
                SQ_BODY: begin
                    if (head_valid) begin
                        lane <= lane + 1'b1;
                        left <= left - 1'b1;
                        if (last_byte) begin
                            state <= SQ_CLOSE;
                        end
                    end
                end
                default: begin
                    state <= SQ_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/msg_frame_tx.sv
module msg_frame_tx
    import msg_frame_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int LEN_W       = 12,
    parameter int WORD_BYTES  = 4,
    parameter int FETCH_DEPTH = 2
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  reg_wr,
    input  logic [1:0]                            reg_addr,
    input  logic [31:0]                           reg_wdata,
    output logic [31:0]                           reg_rdata,
    output logic                                  mem_req,
    output logic [ADDR_W-$clog2(WORD_BYTES)-1:0]  mem_addr,
    input  logic                                  mem_valid,
    input  logic [WORD_BYTES*8-1:0]               mem_rdata,
    output logic                                  out_valid,
    output logic [7:0]                            out_byte,
    output logic                                  frame_start,
    output logic                                  frame_end,
    output logic                                  irq
);
    localparam int LANE_W  = $clog2(WORD_BYTES);
    localparam int WADDR_W = ADDR_W - LANE_W;
    localparam int CNT_W   = LEN_W + 1;
    localparam int DATA_W  = WORD_BYTES * 8;

    logic              launch;
    logic [ADDR_W-1:0] ptr;
    logic [LEN_W-1:0]  len;
    logic              master;
    logic              done_flag;
    logic              busy;
    logic              seq_open;
    logic              seq_close;
    logic              pop;
    logic [DATA_W-1:0] head;
    logic              head_valid;
    logic [CNT_W-1:0]  words;
    logic [LANE_W-1:0] lane0;

    assign lane0 = ptr[LANE_W-1:0];
    assign words = (len == '0) ? '0
                 : CNT_W'((CNT_W'(len) + CNT_W'(lane0) + CNT_W'(WORD_BYTES - 1)) >> LANE_W);

    msg_frame_regs #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .finish    (seq_close),
        .launch    (launch),
        .ptr       (ptr),
        .len       (len),
        .master    (master),
        .done      (done_flag),
        .irq       (irq)
    );

    msg_frame_fetch #(
        .WORD_BYTES (WORD_BYTES),
        .WADDR_W    (WADDR_W),
        .CNT_W      (CNT_W),
        .DEPTH      (FETCH_DEPTH)
    ) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .base       (ptr[ADDR_W-1:LANE_W]),
        .words      (words),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_valid  (mem_valid),
        .mem_rdata  (mem_rdata),
        .pop        (pop),
        .head       (head),
        .head_valid (head_valid)
    );

    msg_frame_seq #(
        .WORD_BYTES (WORD_BYTES),
        .LEN_W      (LEN_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .start_lane  (lane0),
        .len         (len),
        .head        (head),
        .head_valid  (head_valid),
        .pop         (pop),
        .out_valid   (out_valid),
        .out_byte    (out_byte),
        .open_pulse  (seq_open),
        .close_pulse (seq_close),
        .busy        (busy)
    );

    // side-band pins are only driven as sync master
    assign frame_start = master && seq_open;
    assign frame_end   = master && seq_close;

endmodule

// File: rtl/msg_frame_tx_chk.sv
module msg_frame_tx_chk #(
    parameter int WADDR_W = 14
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic [1:0]         reg_addr,
    input logic [31:0]        reg_wdata,
    input logic               mem_req,
    input logic [WADDR_W-1:0] mem_addr,
    input logic               mem_valid,
    input logic               out_valid,
    input logic               frame_start,
    input logic               frame_end,
    input logic               busy,
    input logic               done_flag,
    input logic               seq_close
);
    logic unused_wdata;
    assign unused_wdata = ^reg_wdata;

    p_open_next_r2: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (out_valid || frame_end));

    p_close_done_r5: assert property (@(posedge clk) disable iff (rst)
        seq_close |=> done_flag);

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[3] && !seq_close) |=> !done_flag);

    p_no_master_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[0] && !reg_wdata[1] && !busy) |=> !busy);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!out_valid && !frame_start && !frame_end && !mem_req));

    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    p_addr_step_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_valid) |=> (!mem_req || mem_addr == WADDR_W'($past(mem_addr) + 1'b1)));

    p_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_valid, frame_start, frame_end}));

endmodule

bind msg_frame_tx msg_frame_tx_chk #(.WADDR_W(WADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_valid   (mem_valid),
    .out_valid   (out_valid),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .busy        (busy),
    .done_flag   (done_flag),
    .seq_close   (seq_close)
);

// File: tb/msg_frame_tx_tb_top.sv
module msg_frame_tx_tb_top;
    localparam int WADDR_W = 14;
    localparam logic [9:0] TOK_OPEN  = 10'h100;
    localparam logic [9:0] TOK_CLOSE = 10'h200;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_addr = 2'd0;
    logic [31:0]       reg_wdata = 32'd0;
    logic [31:0]       reg_rdata;
    logic              mem_req;
    logic [WADDR_W-1:0] mem_addr;
    logic              mem_valid = 1'b0;
    logic [31:0]       mem_rdata = 32'd0;
    logic              out_valid;
    logic [7:0]        out_byte;
    logic              frame_start;
    logic              frame_end;
    logic              irq;

    always #4 clk = ~clk;

    msg_frame_tx dut_i (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_byte(out_byte),
        .frame_start(frame_start), .frame_end(frame_end), .irq(irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int ev_cnt = 0;
    int start_cyc = 0;
    int end_cyc = 0;
    bit prev_start = 0;
    bit first_pending = 0;
    int wcnt = 0;
    int lat = 1;
    logic [9:0] exp_q [$];

    function automatic logic [7:0] mbyte(input int a);
        return 8'((a * 7) + 49 + (a >> 5));
    endfunction

    function automatic logic [31:0] mword(input int w);
        return {mbyte(4*w+3), mbyte(4*w+2), mbyte(4*w+1), mbyte(4*w)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // memory model: latency cycles 1..3 rotating
    always @(negedge clk) begin
        if (rst) begin
            mem_valid = 1'b0;
            wcnt = 0;
        end else begin
            mem_valid = 1'b0;
            if (mem_req) begin
                wcnt++;
                if (wcnt >= lat) begin
                    mem_valid = 1'b1;
                    mem_rdata = mword(int'(mem_addr));
                    wcnt = 0;
                    lat = (lat == 3) ? 1 : lat + 1;
                end
            end
        end
    end

    task automatic take(input logic [9:0] tok, input string req);
        logic [9:0] e;
        ev_cnt++;
        if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected output", 32'(tok), 32'h0);
        end else begin
            e = exp_q.pop_front();
            check(tok == e, req, 32'(tok), 32'(e));
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (frame_start) begin
                take(TOK_OPEN, "R2 opening pulse");
                start_cyc = cyc;
                first_pending = 1;
            end
            if (out_valid) begin
                if (first_pending) begin
                    check(prev_start, "R2 first byte right after start", 32'(prev_start), 32'd1);
                    first_pending = 0;
                end
                take({2'b00, out_byte}, "R3 byte stream");
            end
            if (frame_end) begin
                take(TOK_CLOSE, "R4 closing pulse");
                end_cyc = cyc;
                first_pending = 0;
            end
            prev_start = frame_start;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic queue_msg(input int ptr, input int len);
        exp_q.push_back(TOK_OPEN);
        for (int i = 0; i < len; i++) exp_q.push_back({2'b00, mbyte(ptr + i)});
        exp_q.push_back(TOK_CLOSE);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd3, s);
            if (!s[1]) break;
        end
    endtask

    task automatic run_msg(input int ptr, input int len, input bit ien);
        wr(2'd1, 32'(ptr));
        wr(2'd2, 32'(len));
        queue_msg(ptr, len);
        wr(2'd0, {29'd0, ien, 1'b1, 1'b1});
        wait_idle();
        check(exp_q.size() == 0, "R4 whole message delivered", 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R9 actual=hang expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int ev0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check(v == 32'd0, "R1 register after reset", v, 32'd0);
        end
        check({out_valid, frame_start, frame_end, irq, mem_req} == 5'd0, "R1 outputs after reset",
              32'({out_valid, frame_start, frame_end, irq, mem_req}), 32'd0);

        // R2/R3/R4/R5 aligned message with interrupt enabled
        run_msg(32'h40, 8, 1'b1);
        rd(2'd3, v);
        check(v[0] == 1'b1, "R5 done after completion", 32'(v[0]), 32'd1);
        check(irq == 1'b1, "R5 irq with enable", 32'(irq), 32'd1);
        rd(2'd0, v);
        check(v[0] == 1'b0, "R4 run bit cleared", 32'(v[0]), 32'd0);

        // R6 acknowledge
        wr(2'd0, 32'hE);
        rd(2'd3, v);
        check(v[0] == 1'b0, "R6 ack clears done", 32'(v[0]), 32'd0);
        check(irq == 1'b0, "R6 irq drops after ack", 32'(irq), 32'd0);

        // R3 unaligned pointer spanning four words
        run_msg(32'h103, 11, 1'b1);
        wr(2'd0, 32'hE);

        // R5 interrupt disabled
        run_msg(32'h21, 6, 1'b0);
        rd(2'd3, v);
        check(v[0] == 1'b1, "R5 done without enable", 32'(v[0]), 32'd1);
        check(irq == 1'b0, "R5 irq masked", 32'(irq), 32'd0);
        wr(2'd0, 32'hE);

        // R7 zero length
        ev0 = ev_cnt;
        run_msg(32'h80, 0, 1'b1);
        check(end_cyc == start_cyc + 1, "R7 end right after start", 32'(end_cyc - start_cyc), 32'd1);
        check(ev_cnt - ev0 == 2, "R7 no data bytes", 32'(ev_cnt - ev0), 32'd2);
        wr(2'd0, 32'hE);

        // R9 idle after completion
        ev0 = ev_cnt;
        repeat (40) @(negedge clk);
        check(ev_cnt == ev0, "R9 quiet while idle", 32'(ev_cnt - ev0), 32'd0);

        // R8 run without master
        wr(2'd1, 32'h10);
        wr(2'd2, 32'd5);
        ev0 = ev_cnt;
        wr(2'd0, 32'h1);
        repeat (30) @(negedge clk);
        check(ev_cnt == ev0, "R8 nothing sent without master", 32'(ev_cnt - ev0), 32'd0);
        rd(2'd3, v);
        check(v[1] == 1'b0, "R8 not busy", 32'(v[1]), 32'd0);
        rd(2'd0, v);
        check(v[0] == 1'b0, "R8 run bit stays clear", 32'(v[0]), 32'd0);

        // R6 acknowledge colliding with completion
        wr(2'd1, 32'h55);
        wr(2'd2, 32'd7);
        queue_msg(32'h55, 7);
        wr(2'd0, 32'h7);
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (frame_end) break;
        end
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'hE;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'd0;
        rd(2'd3, v);
        check(v[0] == 1'b1, "R6 completion wins over ack", 32'(v[0]), 32'd1);
        wr(2'd0, 32'hE);
        rd(2'd3, v);
        check(v[0] == 1'b0, "R6 later ack clears", 32'(v[0]), 32'd0);

        // R9 restart after idle
        run_msg(32'h200, 9, 1'b1);
        rd(2'd3, v);
        check(v[0] == 1'b1, "R9 restarted message completes", 32'(v[0]), 32'd1);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule